// File: doc/BRIEF.md
# Slot Interrupt Router

This block routes the four shared interrupt pins (A to D, index 0 to 3) of a set of numbered bus slots onto a space of internal interrupt numbers. From each routed number it then drives one interrupt line towards the processor. A requesting source presents its slot number and pin index together with a one-cycle event strobe. The block works out the internal number at once. On the next clock edge it updates the processor line, using two configuration vectors that hold one bit per internal interrupt.

Routing is fixed. The south-side multifunction slot spreads its four pins over four consecutive numbers. Two single-function slots each own one number. A run of expansion slots shares numbers through a rotating swizzle, so that pin A of one slot lands on the same number as pin B of the slot before it. A slot outside these groups passes its pin index through untranslated. That result lies below the internal range, so it cannot touch the processor line.

For an internal interrupt configured as edge-type, an event produces a single-cycle pulse, and the line is left low afterwards. For a level-type interrupt the line follows the polarity bit and holds that value until the next event.

Top module: `slot_int_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cpu_irq` is low.
- R2: For slot 5, `route_num` equals 32 + pin, with the pin taken modulo 4.
- R3: Slot 6 routes to 36 and slot 7 routes to 37, whatever the pin.
- R4: Slots 8 to 12 route to 38 + (slot - 8) + pin.
- R5: Any other slot routes to the pin index itself, from 0 to 3.
- R6: An event whose internal index (route_num - 32, valid only for 0 to 31) has its `edge_cfg` bit set raises `cpu_irq` in the cycle after the event, for exactly one cycle. The line is then low unless another event follows.
- R7: An in-range event with its `edge_cfg` bit clear and its `pol_cfg` bit set drives `cpu_irq` high from the next cycle on. The line holds high until a later in-range event changes it.
- R8: An in-range event with its `edge_cfg` bit clear and its `pol_cfg` bit clear drives `cpu_irq` low from the next cycle on, and holds it low.
- R9: An event whose internal index falls outside 0 to 31 leaves the held level of `cpu_irq` unchanged, whatever `edge_cfg` and `pol_cfg` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe: the source's level changed |
| evt_slot | input | 5 | Slot number of the requesting source |
| evt_pin | input | 2 | Pin index of the source, 0 to 3 |
| edge_cfg | input | 32 | Per internal interrupt: 1 selects pulse mode |
| pol_cfg | input | 32 | Per internal interrupt in level mode: value to drive |
| route_num | output | 7 | Routed interrupt number (combinational) |
| cpu_irq | output | 1 | Processor interrupt line |

## Verification
The hardest situations to reach combine the drive modes with state that is already on the line. One is an edge-mode pulse issued while the line is held high by a level interrupt. The other is an out-of-range event arriving while every configuration bit is set. The stimulus first sets the line high through a level-mode slot 5 pin. It then fires the single-function slot 6 in edge mode, which must pulse and then leave the line low. It then restores the high level and fires an unlisted slot with both configuration vectors all ones, checking that the line does not move. The route table covers the swizzle wrap by giving two expansion slots the same routed number.

// File: rtl/sir_pkg.sv
package sir_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_PULSE = 2'd1,
      ACT_HIGH  = 2'd2,
      ACT_LOW   = 2'd3
   } sir_act_e;
endpackage

// File: rtl/sir_slot_map.sv
module sir_slot_map #(
   parameter int SLOT_W    = 5,
   parameter int PIN_W     = 2,
   parameter int NUM_W     = 7,
   parameter int INT_BASE  = 32,
   parameter int SOUTH_SLOT = 5,
   parameter int GFX_SLOT  = 6,
   parameter int GFX_IDX   = 4,
   parameter int NIC_SLOT  = 7,
   parameter int NIC_IDX   = 5,
   parameter int EXP_FIRST = 8,
   parameter int EXP_COUNT = 5,
   parameter int EXP_IDX   = 6
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic [PIN_W-1:0]  pin,
   output logic [NUM_W-1:0]  num
);
   logic [NUM_W-1:0]     pin_ext;
   logic [NUM_W-1:0]     pin_mod4;
   logic [EXP_COUNT-1:0] exp_hit;
   logic [NUM_W-1:0]     exp_num [EXP_COUNT];

   assign pin_ext  = NUM_W'(pin);
   assign pin_mod4 = NUM_W'(pin % 4);

   // one comparator and adder per expansion slot: the swizzle rotates by slot offset
   for (genvar i = 0; i < EXP_COUNT; i++) begin : g_exp
      assign exp_hit[i] = (slot == SLOT_W'(EXP_FIRST + i));
      assign exp_num[i] = NUM_W'(INT_BASE + EXP_IDX + i) + pin_ext;
   end

   always_comb begin
      num = pin_ext;
      if (slot == SLOT_W'(SOUTH_SLOT)) begin
         num = NUM_W'(INT_BASE) + pin_mod4;
      end else if (slot == SLOT_W'(GFX_SLOT)) begin
         num = NUM_W'(INT_BASE + GFX_IDX);
      end else if (slot == SLOT_W'(NIC_SLOT)) begin
         num = NUM_W'(INT_BASE + NIC_IDX);
      end else begin
         for (int k = 0; k < EXP_COUNT; k++) begin
            if (exp_hit[k]) num = exp_num[k];
         end
      end
   end
endmodule

// File: rtl/sir_cfg_lookup.sv
module sir_cfg_lookup
   import sir_pkg::*;
#(
   parameter int NUM_W    = 7,
   parameter int INT_BASE = 32,
   parameter int N_INT    = 32
) (
   input  logic [NUM_W-1:0] num,
   input  logic [N_INT-1:0] edge_cfg,
   input  logic [N_INT-1:0] pol_cfg,
   output sir_act_e         act
);
   localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1;

   logic             in_range;
   logic [IDX_W-1:0] idx;

   assign in_range = (int'(num) >= INT_BASE) && (int'(num) < INT_BASE + N_INT);
   assign idx      = IDX_W'(int'(num) - INT_BASE);

   always_comb begin
      act = ACT_HOLD;
      if (in_range) begin
         if (edge_cfg[idx])     act = ACT_PULSE;
         else if (pol_cfg[idx]) act = ACT_HIGH;
         else                   act = ACT_LOW;
      end
   end
endmodule

// File: rtl/sir_drive.sv
module sir_drive
   import sir_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     fire,
   input  sir_act_e act,
   output logic     irq
);
   logic held_q;
   logic pulse_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_q  <= 1'b0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= 1'b0;
         if (fire) begin
            unique case (act)
               ACT_PULSE: begin
                  pulse_q <= 1'b1;
                  held_q  <= 1'b0;
               end
               ACT_HIGH: held_q <= 1'b1;
               ACT_LOW:  held_q <= 1'b0;
               default:  held_q <= held_q;
            endcase
         end
      end
   end

   assign irq = held_q | pulse_q;
endmodule

// File: rtl/slot_int_router.sv
module slot_int_router
   import sir_pkg::*;
#(
   parameter int SLOT_W     = 5,
   parameter int PIN_W      = 2,
   parameter int NUM_W      = 7,
   parameter int INT_BASE   = 32,
   parameter int N_INT      = 32,
   parameter int SOUTH_SLOT = 5,
   parameter int GFX_SLOT   = 6,
   parameter int GFX_IDX    = 4,
   parameter int NIC_SLOT   = 7,
   parameter int NIC_IDX    = 5,
   parameter int EXP_FIRST  = 8,
   parameter int EXP_COUNT  = 5,
   parameter int EXP_IDX    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [SLOT_W-1:0] evt_slot,
   input  logic [PIN_W-1:0]  evt_pin,
   input  logic [N_INT-1:0]  edge_cfg,
   input  logic [N_INT-1:0]  pol_cfg,
   output logic [NUM_W-1:0]  route_num,
   output logic              cpu_irq
);
   localparam int MAX_NUM  = INT_BASE + EXP_IDX + EXP_COUNT - 1 + (1 << PIN_W) - 1;
   localparam int MAX_SLOT = EXP_FIRST + EXP_COUNT - 1;

   if (MAX_NUM >= (1 << NUM_W)) begin : g_chk_num
      $error("NUM_W too narrow for the highest routed number");
   end
   if (MAX_SLOT >= (1 << SLOT_W)) begin : g_chk_slot
      $error("SLOT_W too narrow for the last expansion slot");
   end
   if (EXP_COUNT < 1) begin : g_chk_exp
      $error("EXP_COUNT must be at least 1");
   end

   sir_act_e act;

   sir_slot_map #(
      .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W), .INT_BASE(INT_BASE),
      .SOUTH_SLOT(SOUTH_SLOT), .GFX_SLOT(GFX_SLOT), .GFX_IDX(GFX_IDX),
      .NIC_SLOT(NIC_SLOT), .NIC_IDX(NIC_IDX),
      .EXP_FIRST(EXP_FIRST), .EXP_COUNT(EXP_COUNT), .EXP_IDX(EXP_IDX)
   ) u_map (
      .slot(evt_slot),
      .pin (evt_pin),
      .num (route_num)
   );

   sir_cfg_lookup #(
      .NUM_W(NUM_W), .INT_BASE(INT_BASE), .N_INT(N_INT)
   ) u_lookup (
      .num     (route_num),
      .edge_cfg(edge_cfg),
      .pol_cfg (pol_cfg),
      .act     (act)
   );

   sir_drive u_drive (
      .clk  (clk),
      .rst_n(rst_n),
      .fire (evt_valid),
      .act  (act),
      .irq  (cpu_irq)
   );
endmodule

// File: rtl/sir_checker.sv
module sir_checker #(
   parameter int SLOT_W   = 5,
   parameter int PIN_W    = 2,
   parameter int NUM_W    = 7,
   parameter int INT_BASE = 32,
   parameter int N_INT    = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic [SLOT_W-1:0] evt_slot,
   input logic [PIN_W-1:0]  evt_pin,
   input logic [N_INT-1:0]  edge_cfg,
   input logic [N_INT-1:0]  pol_cfg,
   input logic [NUM_W-1:0]  route_num,
   input logic              cpu_irq
);
   localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1;

   logic             hit;
   logic [IDX_W-1:0] idx;
   logic             ev_in;
   logic             ev_edge;

   assign hit     = (int'(route_num) >= INT_BASE) && (int'(route_num) < INT_BASE + N_INT);
   assign idx     = IDX_W'(int'(route_num) - INT_BASE);
   assign ev_in   = evt_valid && hit;
   assign ev_edge = ev_in && edge_cfg[idx];

   a_r1_low_after_reset: assert property (@(posedge clk)
      !rst_n |=> !cpu_irq);

   a_r2_south_route: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_slot == SLOT_W'(5)) |-> (int'(route_num) == INT_BASE + int'(evt_pin % 4)));

   a_r3_single_route: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_slot == SLOT_W'(6)) |-> (int'(route_num) == INT_BASE + 4));

   a_r6_pulse_rises: assert property (@(posedge clk) disable iff (!rst_n)
      ev_edge |=> cpu_irq);

   a_r6_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
      ev_edge ##1 !ev_in |=> !cpu_irq);

   a_r7_level_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in && !edge_cfg[idx] && pol_cfg[idx]) |=> cpu_irq);

   a_r8_level_low: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_in && !edge_cfg[idx] && !pol_cfg[idx]) |=> !cpu_irq);

   a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_in && !$past(ev_edge)) |=> $stable(cpu_irq));
endmodule

bind slot_int_router sir_checker #(
   .SLOT_W(SLOT_W), .PIN_W(PIN_W), .NUM_W(NUM_W),
   .INT_BASE(INT_BASE), .N_INT(N_INT)
) u_chk (.*);

// File: tb/tb_slot_int_router.sv
module tb_slot_int_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        evt_valid = 1'b0;
   logic [4:0]  evt_slot = '0;
   logic [1:0]  evt_pin = '0;
   logic [31:0] edge_cfg = '0;
   logic [31:0] pol_cfg = '0;
   logic [6:0]  route_num;
   logic        cpu_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   slot_int_router dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_slot(evt_slot),
      .evt_pin(evt_pin), .edge_cfg(edge_cfg), .pol_cfg(pol_cfg),
      .route_num(route_num), .cpu_irq(cpu_irq)
   );

   // {slot[4:0], pin[1:0], expected number[6:0]}
   localparam int NV = 16;
   localparam logic [13:0] VEC [NV] = '{
      {5'd5,  2'd0, 7'd32}, {5'd5,  2'd3, 7'd35}, {5'd6,  2'd0, 7'd36},
      {5'd6,  2'd2, 7'd36}, {5'd7,  2'd1, 7'd37}, {5'd7,  2'd3, 7'd37},
      {5'd8,  2'd0, 7'd38}, {5'd8,  2'd3, 7'd41}, {5'd9,  2'd2, 7'd41},
      {5'd10, 2'd1, 7'd41}, {5'd12, 2'd0, 7'd42}, {5'd12, 2'd3, 7'd45},
      {5'd4,  2'd2, 7'd2},  {5'd0,  2'd1, 7'd1},  {5'd13, 2'd3, 7'd3},
      {5'd31, 2'd0, 7'd0}
   };

   function automatic string tag_of(input logic [4:0] s);
      if (s == 5'd5) return "R2";
      if (s == 5'd6 || s == 5'd7) return "R3";
      if (s >= 5'd8 && s <= 5'd12) return "R4";
      return "R5";
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // event strobe for one cycle; returns at the negedge after the update edge
   task automatic fire(input logic [4:0] s, input logic [1:0] p);
      @(negedge clk);
      evt_slot  = s;
      evt_pin   = p;
      evt_valid = 1'b1;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   initial begin
      #100000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", 32'(cpu_irq), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(cpu_irq), 32'd0);

      // route table
      for (int i = 0; i < NV; i++) begin
         evt_slot = VEC[i][13:9];
         evt_pin  = VEC[i][8:7];
         #1;
         check(tag_of(VEC[i][13:9]), 32'(route_num), 32'(VEC[i][6:0]));
      end

      // R7: slot 5 pin 1 -> index 1, level, polarity high
      pol_cfg[1] = 1'b1;
      fire(5'd5, 2'd1);
      check("R7", 32'(cpu_irq), 32'd1);
      repeat (3) @(negedge clk);
      check("R7", 32'(cpu_irq), 32'd1);

      // R8: slot 5 pin 2 -> index 2, level, polarity low
      fire(5'd5, 2'd2);
      check("R8", 32'(cpu_irq), 32'd0);
      repeat (2) @(negedge clk);
      check("R8", 32'(cpu_irq), 32'd0);

      // R6: slot 6 -> index 4, edge mode
      edge_cfg[4] = 1'b1;
      fire(5'd6, 2'd3);
      check("R6", 32'(cpu_irq), 32'd1);
      @(negedge clk);
      check("R6", 32'(cpu_irq), 32'd0);

      // R6: pulse on top of a held high level ends low
      fire(5'd5, 2'd1);
      check("R7", 32'(cpu_irq), 32'd1);
      fire(5'd6, 2'd0);
      check("R6", 32'(cpu_irq), 32'd1);
      @(negedge clk);
      check("R6", 32'(cpu_irq), 32'd0);

      // R9: out-of-range routes leave the line alone
      fire(5'd5, 2'd1);
      edge_cfg = '1;
      pol_cfg  = '1;
      fire(5'd3, 2'd0);
      check("R9", 32'(cpu_irq), 32'd1);
      fire(5'd20, 2'd3);
      @(negedge clk);
      check("R9", 32'(cpu_irq), 32'd1);
      edge_cfg = '0;
      pol_cfg  = '0;
      fire(5'd5, 2'd1);
      check("R8", 32'(cpu_irq), 32'd0);
      edge_cfg = '1;
      fire(5'd0, 2'd2);
      @(negedge clk);
      check("R9", 32'(cpu_irq), 32'd0);

      // R4: expansion slot 12 pin 3 -> index 13, level high
      edge_cfg = '0;
      pol_cfg  = 32'h0000_2000;
      fire(5'd12, 2'd3);
      check("R4", 32'(cpu_irq), 32'd1);

      // R1: reset mid-run clears a held high
      rst_n = 1'b0;
      @(negedge clk);
      check("R1", 32'(cpu_irq), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", 32'(cpu_irq), 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule